// File: doc/BRIEF.md
# Nibble Instruction Sequencer

This block is the control unit of a small four-bit processor. It steps through a program of up to 32 instruction words held in a parameter array. For each word it decodes a four-bit opcode and then issues the needed memory and ALU commands one at a time. Each command is a request that stays high until the datapath answers with a one-cycle completion pulse. The datapath blocks are outside this unit. The sequencer only drives their command strobes and fields, and it moves a five-bit program counter.

An instruction word is 15 bits wide. The opcode is in bits [14:11]. The first argument, `arg1`, is in bits [10:6]: it is a five-bit jump target, or a memory address in its low four bits. The second argument, `arg2`, is in bits [5:2]: it is a memory address, or a select code in its low bits. Bits [1:0] are spare. The opcodes are:

| Code | Instruction | Code | Instruction |
|------|-------------|------|-------------|
| 0 | no-op | 8 | XOR |
| 1 | read | 9 | NOT |
| 2 | write | A | jump |
| 3 | add | B | jump if flag set |
| 4 | subtract | C | jump if flag clear |
| 5 | multiply | D | bus swap |
| 6 | OR | E | halt |
| 7 | AND | F | treated as no-op |

The conditional jumps test one bit of a three-bit comparison input. The selected bit is chosen by `arg2[1:0]`: 00 tests the greater flag (bit 0), 01 the less flag (bit 1), 10 the equal flag (bit 2), and 11 is a condition that is always false.

The state machine has nine states:

- FETCH latches the word at the program counter.
- DECODE dispatches on the opcode:
  - halt goes to HALT;
  - read and write go to MEM;
  - ALU opcodes go to OPA;
  - swap goes to SWAP;
  - all other opcodes go to NEXT.
- OPA reads the first operand. When the memory completes, it goes to ALU for NOT and to OPB otherwise.
- OPB reads the second operand, then goes to ALU on completion.
- ALU strobes the ALU and goes to NEXT when the ALU completes.
- MEM performs a single read or write and goes to NEXT on completion.
- SWAP pulses for one cycle and goes to NEXT.
- NEXT loads the new program counter and returns to FETCH.
- HALT has no exit except reset.

Top module: `nib_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pc` is 0, `halted` is 0 and no request or pulse is active.
- R2: Every instruction that does not jump advances `pc` by one, and `pc` wraps from 31 to 0.
- R3: A read (opcode 1) makes exactly one memory request with `mem_we`=0, address `arg1[3:0]`, and `mem_sel`={0,`arg2[0]`}. In `mem_sel`, 0 is the primary bus and 1 is the secondary bus.
- R4: A write (opcode 2) makes exactly one memory request with `mem_we`=1, address `arg1[3:0]`, and `mem_sel`=`arg2[1:0]` as the source code.
- R5: A two-operand ALU opcode (3 to 8) makes three requests in this order:
  1. a read of `arg1[3:0]` with `mem_sel`=0;
  2. a read of `arg2` with `mem_sel`=1;
  3. one ALU request with `alu_op` equal to the opcode.
- R6: NOT (opcode 9) makes one read of `arg1[3:0]` with `mem_sel`=0, then one ALU request with `alu_op`=9.
- R7: At most one request is high at a time. A request stays high, with its fields stable, until its completion pulse. The next step begins only after that pulse.
- R8: A jump (opcode A) loads `pc` with `arg1` (five bits).
- R9: A jump-if-set (opcode B) branches to `arg1` when the selected flag is 1, and a jump-if-clear (opcode C) branches when it is 0. Select 11 counts as a flag of 0.
- R10: A bus swap (opcode D) raises `swap_pulse` for exactly one cycle and makes no memory or ALU request.
- R11: A halt (opcode E) sets `halted`. After that, `halted` stays set, `pc` does not change, and no request or pulse appears until reset.
- R12: A no-op (opcode 0) and the unused code F issue nothing and advance `pc` by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory request, held until `mem_done` |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 4 | Memory address |
| mem_sel | output | 2 | Bus select for a read, source code for a write |
| mem_done | input | 1 | One-cycle memory completion pulse |
| alu_req | output | 1 | ALU request, held until `alu_done` |
| alu_op | output | 4 | Opcode of the ALU operation |
| alu_done | input | 1 | One-cycle ALU completion pulse |
| swap_pulse | output | 1 | One-cycle command to exchange the primary and secondary buses |
| cmp_flags | input | 3 | Comparison flags: bit 0 greater, bit 1 less, bit 2 equal |
| pc | output | 5 | Program counter |
| halted | output | 1 | Set once a halt has executed |

## Verification
Most wrong internal states of this sequencer show up at the ports within one instruction:

- A mis-decoded opcode, or a wrong branch decision, changes the sequence of `pc` values at the next NEXT state, two or three cycles after the fetch.
- A wrong address or select field, or a missing or misordered operand read, appears in the memory request log as soon as that request completes.
- A state machine that leaves a wait state early, or holds a request past its completion, breaks the handshake in that cycle.
- A halt that does not hold shows up as `pc` movement or a request within a few cycles.

The bench sweeps all eight comparison flag values against every select code, in both jump forms, and runs the memory and ALU at four different response latencies.

// File: rtl/nib_seq_pkg.sv
package nib_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'h0,
        OP_READ  = 4'h1,
        OP_WRITE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_MUL   = 4'h5,
        OP_OR    = 4'h6,
        OP_AND   = 4'h7,
        OP_XOR   = 4'h8,
        OP_NOT   = 4'h9,
        OP_JMP   = 4'hA,
        OP_JSET  = 4'hB,
        OP_JCLR  = 4'hC,
        OP_SWAP  = 4'hD,
        OP_HALT  = 4'hE,
        OP_RSVD  = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_OPA    = 4'd2,
        ST_OPB    = 4'd3,
        ST_ALU    = 4'd4,
        ST_MEM    = 4'd5,
        ST_SWAP   = 4'd6,
        ST_NEXT   = 4'd7,
        ST_HALT   = 4'd8
    } state_e;

    // Instruction classes produced by the decoder.
    typedef struct packed {
        logic mem_single;   // read or write
        logic mem_write;    // write
        logic two_op;       // ALU op with two operands
        logic one_op;       // ALU op with one operand
        logic jump;         // unconditional jump
        logic cond;         // conditional jump
        logic cond_inv;     // branch on a clear flag
        logic swap;         // bus swap
        logic halt;         // halt
    } dec_t;

    localparam int OPC_W   = 4;
    localparam int SPARE_W = 2;
    localparam int FLAG_W  = 3;
    localparam int SEL_W   = 2;

endpackage

// File: rtl/nib_prog_rom.sv
module nib_prog_rom #(
    parameter int PC_W  = 5,
    parameter int IW    = 15,
    parameter int SPARE = 2,
    localparam int LINES = 1 << PC_W,
    localparam int UW    = IW - SPARE,
    parameter logic [LINES*IW-1:0] PROG = '0
) (
    input  logic [PC_W-1:0] addr,
    output logic [UW-1:0]   word
);
    // Spare low bits of each line are dropped here; nothing uses them.
    always_comb begin
        word = PROG[int'(addr) * IW + SPARE +: UW];
    end
endmodule

// File: rtl/nib_decoder.sv
module nib_decoder
    import nib_seq_pkg::*;
#(
    parameter int PC_W    = 5,
    parameter int MADDR_W = 4,
    localparam int UW     = OPC_W + PC_W + MADDR_W
) (
    input  logic [UW-1:0]      word,
    output opcode_e            opcode,
    output logic [PC_W-1:0]    arg1,
    output logic [MADDR_W-1:0] arg2,
    output dec_t               dec
);
    always_comb begin
        opcode = opcode_e'(word[UW-1 -: OPC_W]);
        arg1   = word[MADDR_W +: PC_W];
        arg2   = word[MADDR_W-1:0];
    end

    always_comb begin
        dec = '0;
        unique case (opcode)
            OP_READ:  dec.mem_single = 1'b1;
            OP_WRITE: begin
                dec.mem_single = 1'b1;
                dec.mem_write  = 1'b1;
            end
            OP_ADD, OP_SUB, OP_MUL,
            OP_OR, OP_AND, OP_XOR: dec.two_op = 1'b1;
            OP_NOT:   dec.one_op = 1'b1;
            OP_JMP:   dec.jump   = 1'b1;
            OP_JSET:  dec.cond   = 1'b1;
            OP_JCLR:  begin
                dec.cond     = 1'b1;
                dec.cond_inv = 1'b1;
            end
            OP_SWAP:  dec.swap   = 1'b1;
            OP_HALT:  dec.halt   = 1'b1;
            OP_NOP, OP_RSVD: dec = '0;
            default:  dec = '0;
        endcase
    end
endmodule

// File: rtl/nib_branch_eval.sv
module nib_branch_eval
    import nib_seq_pkg::*;
#(
    parameter int PC_W = 5
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [PC_W-1:0]   target,
    input  logic [SEL_W-1:0]  csel,
    input  logic [FLAG_W-1:0] flags,
    input  logic              jump,
    input  logic              cond,
    input  logic              cond_inv,
    output logic [PC_W-1:0]   next_pc
);
    logic [(1<<SEL_W)-1:0] sel_vec;
    logic                  flag;
    logic                  take;

    // Select codes past the last flag read as a constant false.
    for (genvar k = 0; k < (1 << SEL_W); k++) begin : g_sel
        if (k < FLAG_W) begin : g_flag
            assign sel_vec[k] = flags[k];
        end else begin : g_never
            assign sel_vec[k] = 1'b0;
        end
    end

    always_comb begin
        flag    = sel_vec[csel];
        take    = jump | (cond & (flag ^ cond_inv));
        next_pc = take ? target : PC_W'(pc + 1'b1);
    end
endmodule

// File: rtl/nib_sequencer.sv
module nib_sequencer
    import nib_seq_pkg::*;
#(
    parameter int PC_W    = 5,
    parameter int MADDR_W = 4,
    localparam int IW     = OPC_W + PC_W + MADDR_W + SPARE_W,
    localparam int UW     = IW - SPARE_W,
    localparam int LINES  = 1 << PC_W,
    parameter logic [LINES*IW-1:0] PROG = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               mem_req,
    output logic               mem_we,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [SEL_W-1:0]   mem_sel,
    input  logic               mem_done,
    output logic               alu_req,
    output logic [OPC_W-1:0]   alu_op,
    input  logic               alu_done,
    output logic               swap_pulse,
    input  logic [FLAG_W-1:0]  cmp_flags,
    output logic [PC_W-1:0]    pc,
    output logic               halted
);
    state_e             state_q, state_d;
    logic [PC_W-1:0]    pc_q;
    logic [UW-1:0]      ir_q;
    logic [UW-1:0]      rom_word;
    opcode_e            opcode;
    logic [PC_W-1:0]    arg1;
    logic [MADDR_W-1:0] arg2;
    dec_t               dec;
    logic [PC_W-1:0]    next_pc;

    nib_prog_rom #(
        .PC_W (PC_W),
        .IW   (IW),
        .SPARE(SPARE_W),
        .PROG (PROG)
    ) u_rom (
        .addr(pc_q),
        .word(rom_word)
    );

    nib_decoder #(
        .PC_W   (PC_W),
        .MADDR_W(MADDR_W)
    ) u_dec (
        .word  (ir_q),
        .opcode(opcode),
        .arg1  (arg1),
        .arg2  (arg2),
        .dec   (dec)
    );

    nib_branch_eval #(
        .PC_W(PC_W)
    ) u_br (
        .pc      (pc_q),
        .target  (arg1),
        .csel    (arg2[SEL_W-1:0]),
        .flags   (cmp_flags),
        .jump    (dec.jump),
        .cond    (dec.cond),
        .cond_inv(dec.cond_inv),
        .next_pc (next_pc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                if (dec.halt)                    state_d = ST_HALT;
                else if (dec.mem_single)         state_d = ST_MEM;
                else if (dec.two_op | dec.one_op) state_d = ST_OPA;
                else if (dec.swap)               state_d = ST_SWAP;
                else                             state_d = ST_NEXT;
            end
            ST_OPA:    if (mem_done) state_d = dec.one_op ? ST_ALU : ST_OPB;
            ST_OPB:    if (mem_done) state_d = ST_ALU;
            ST_ALU:    if (alu_done) state_d = ST_NEXT;
            ST_MEM:    if (mem_done) state_d = ST_NEXT;
            ST_SWAP:   state_d = ST_NEXT;
            ST_NEXT:   state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_FETCH;
        endcase
    end

    // Instruction and program counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
            pc_q <= '0;
        end else begin
            if (state_q == ST_FETCH) ir_q <= rom_word;
            if (state_q == ST_NEXT)  pc_q <= next_pc;
        end
    end

    // Outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_sel    = '0;
        alu_req    = 1'b0;
        alu_op     = '0;
        swap_pulse = 1'b0;
        unique case (state_q)
            ST_OPA: begin
                mem_req  = 1'b1;
                mem_addr = arg1[MADDR_W-1:0];
                mem_sel  = SEL_W'(0);
            end
            ST_OPB: begin
                mem_req  = 1'b1;
                mem_addr = arg2;
                mem_sel  = SEL_W'(1);
            end
            ST_MEM: begin
                mem_req  = 1'b1;
                mem_we   = dec.mem_write;
                mem_addr = arg1[MADDR_W-1:0];
                mem_sel  = dec.mem_write ? arg2[SEL_W-1:0]
                                         : {{(SEL_W-1){1'b0}}, arg2[0]};
            end
            ST_ALU: begin
                alu_req = 1'b1;
                alu_op  = opcode;
            end
            ST_SWAP: swap_pulse = 1'b1;
            ST_FETCH, ST_DECODE, ST_NEXT, ST_HALT: ;
            default: ;
        endcase
    end

    assign pc     = pc_q;
    assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/nib_sequencer_chk.sv
module nib_sequencer_chk #(
    parameter int PC_W    = 5,
    parameter int MADDR_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic               mem_we,
    input logic [MADDR_W-1:0] mem_addr,
    input logic [1:0]         mem_sel,
    input logic               mem_done,
    input logic               alu_req,
    input logic [3:0]         alu_op,
    input logic               alu_done,
    input logic               swap_pulse,
    input logic [PC_W-1:0]    pc,
    input logic               halted
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !halted && !mem_req && !alu_req && !swap_pulse));

    assert_one_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && alu_req));

    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_sel)));

    assert_alu_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req && !alu_done) |=> (alu_req && $stable(alu_op)));

    assert_swap_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (!mem_req && !alu_req));

    assert_swap_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> !swap_pulse);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc)));

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !alu_req && !swap_pulse));
endmodule

bind nib_sequencer nib_sequencer_chk #(
    .PC_W   (PC_W),
    .MADDR_W(MADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_sel   (mem_sel),
    .mem_done  (mem_done),
    .alu_req   (alu_req),
    .alu_op    (alu_op),
    .alu_done  (alu_done),
    .swap_pulse(swap_pulse),
    .pc        (pc),
    .halted    (halted)
);

// File: tb/nib_sequencer_test.sv
module nib_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 5;
    localparam int MA_W  = 4;
    localparam int IW    = 15;
    localparam int LINES = 32;

    function automatic logic [IW-1:0] ins(int op, int a1, int a2);
        ins = {op[3:0], a1[4:0], a2[3:0], 2'b00};
    endfunction

    // Program: line 0 branches on "equal" to 30; 30 subtracts; 31 no-op wraps to 0;
    // lines 1..15 odd are conditional jumps over the no-op that follows each.
    function automatic logic [LINES*IW-1:0] build_prog();
        logic [LINES*IW-1:0] p;
        p = '0;
        p[0*IW +: IW] = ins(11, 30, 2);
        for (int i = 0; i < 8; i++)
            p[(2*i+1)*IW +: IW] = ins((i < 4) ? 11 : 12, 2*i+3, i % 4);
        p[17*IW +: IW] = ins(1, 5, 1);
        p[18*IW +: IW] = ins(2, 9, 2);
        p[19*IW +: IW] = ins(3, 3, 12);
        p[20*IW +: IW] = ins(9, 7, 0);
        p[21*IW +: IW] = ins(13, 0, 0);
        p[22*IW +: IW] = ins(5, 15, 0);
        p[23*IW +: IW] = ins(15, 0, 0);
        p[24*IW +: IW] = ins(10, 27, 0);
        p[25*IW +: IW] = ins(14, 0, 0);
        p[26*IW +: IW] = ins(14, 0, 0);
        p[27*IW +: IW] = ins(8, 1, 2);
        p[28*IW +: IW] = ins(14, 0, 0);
        p[30*IW +: IW] = ins(4, 4, 6);
        return p;
    endfunction

    localparam logic [LINES*IW-1:0] PROG = build_prog();

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mem_req, mem_we, alu_req, swap_pulse, halted;
    logic [MA_W-1:0] mem_addr;
    logic [1:0]      mem_sel;
    logic            mem_done = 1'b0;
    logic [3:0]      alu_op;
    logic            alu_done = 1'b0;
    logic [2:0]      cmp_flags = 3'b100;
    logic [PC_W-1:0] pc;

    nib_sequencer #(.PC_W(PC_W), .MADDR_W(MA_W), .PROG(PROG)) uut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_sel(mem_sel),
        .mem_done(mem_done),
        .alu_req(alu_req), .alu_op(alu_op), .alu_done(alu_done),
        .swap_pulse(swap_pulse), .cmp_flags(cmp_flags),
        .pc(pc), .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int lat = 0, run_flags = 0, phase = 0;
    int mcnt = 0, acnt = 0;
    int mem_n = 0, alu_n = 0, swap_n = 0, pc_n = 0;
    int mem_log[64];
    int alu_log[64];
    int pc_log[64];
    int last_pc = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Memory and ALU responders, event monitor, flag sequencing (all at negedge).
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_done = 1'b0; alu_done = 1'b0; mcnt = 0; acnt = 0;
            end else begin
                if (mem_done) begin
                    mem_done = 1'b0; mcnt = 0;
                end else if (mem_req) begin
                    if (mcnt == lat) begin
                        mem_done = 1'b1;
                        if (mem_n < 64) mem_log[mem_n] = {mem_we, mem_addr, mem_sel};
                        mem_n++;
                    end else mcnt++;
                end
                if (alu_done) begin
                    alu_done = 1'b0; acnt = 0;
                end else if (alu_req) begin
                    if (acnt == lat) begin
                        alu_done = 1'b1;
                        if (alu_n < 64) alu_log[alu_n] = alu_op;
                        alu_n++;
                    end else acnt++;
                end
                if (swap_pulse) swap_n++;
                if (pc != last_pc) begin
                    if (pc_n < 64) pc_log[pc_n] = pc;
                    pc_n++;
                    last_pc = pc;
                end
                if (phase == 0 && pc == 30) begin
                    cmp_flags = 3'b000; phase = 1;
                end else if (phase == 1 && pc == 1) begin
                    cmp_flags = run_flags[2:0]; phase = 2;
                end
            end
        end
    end

    task automatic run(int f);
        int exp_pc[64];
        int exp_mem[11];
        int exp_alu[5];
        int n;
        int waited;
        int m0, a0, s0;
        rst_n = 1'b0;
        @(negedge clk);
        lat = f % 4; run_flags = f; phase = 0; cmp_flags = 3'b100;
        mem_n = 0; alu_n = 0; swap_n = 0; pc_n = 1; pc_log[0] = 0; last_pc = 0;
        repeat (2) @(negedge clk);
        chk("R1 reset pc", pc, 0);
        chk("R1 reset halted", halted, 0);
        chk("R1 reset requests", {mem_req, alu_req, swap_pulse}, 0);
        rst_n = 1'b1;
        waited = 0;
        while (!halted && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk("R11 halt reached", halted, 1);

        // expected pc trace
        n = 0;
        exp_pc[n++] = 0; exp_pc[n++] = 30; exp_pc[n++] = 31; exp_pc[n++] = 0; exp_pc[n++] = 1;
        for (int i = 0; i < 8; i++) begin
            int sel;
            bit c, take;
            sel  = i % 4;
            c    = (sel == 3) ? 1'b0 : f[sel];
            take = (i < 4) ? c : !c;
            if (!take) exp_pc[n++] = 2*i + 2;
            exp_pc[n++] = 2*i + 3;
        end
        for (int l = 18; l <= 24; l++) exp_pc[n++] = l;
        exp_pc[n++] = 27;
        exp_pc[n++] = 28;
        chk("R2 R8 R9 R12 pc trace length", pc_n, n);
        for (int i = 0; i < n && i < pc_n; i++)
            chk($sformatf("R2 R8 R9 R12 pc trace step %0d flags %0d", i, f), pc_log[i], exp_pc[i]);

        // expected memory requests: {we, addr, sel}
        exp_mem = '{ (4<<2)|0, (6<<2)|1, (5<<2)|1, 64|(9<<2)|2, (3<<2)|0, (12<<2)|1,
                     (7<<2)|0, (15<<2)|0, (0<<2)|1, (1<<2)|0, (2<<2)|1 };
        chk("R3 R4 R5 R6 R7 memory request count", mem_n, 11);
        for (int i = 0; i < 11 && i < mem_n; i++)
            chk($sformatf("R3 R4 R5 R6 R7 memory request %0d", i), mem_log[i], exp_mem[i]);
        exp_alu = '{4, 3, 9, 5, 8};
        chk("R5 R6 alu request count", alu_n, 5);
        for (int i = 0; i < 5 && i < alu_n; i++)
            chk($sformatf("R5 R6 alu op %0d", i), alu_log[i], exp_alu[i]);
        chk("R10 swap pulses", swap_n, 1);

        // hold after halt
        m0 = mem_n; a0 = alu_n; s0 = swap_n;
        repeat (20) @(negedge clk);
        chk("R11 pc frozen", pc, 28);
        chk("R11 still halted", halted, 1);
        chk("R11 no activity after halt", (mem_n - m0) + (alu_n - a0) + (swap_n - s0), 0);
    endtask

    initial begin
        repeat (200000 - 50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int f = 0; f < 8; f++) run(f);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule